// File: doc/BRIEF.md
# Periodic Tick Interrupt Generator

This block raises a periodic interrupt flag at one of four rates. A free-running divider counts bus clock cycles. When it completes a period it sets a sticky flag and begins the next period at once. The period is `2^BASE_LOG2` cycles (8192 by default), multiplied by 1, 2, 4 or 8. A 2-bit rate field in the control register picks the multiplier.

Software uses a small byte-wide register port to program the rate, enable the interrupt and acknowledge the flag. The flag is cleared by writing 1 to it. Any write to the control register starts a new period from zero, and that write never sets the flag. The upper control bits and the upper enable-register bits have no effect, but they hold whatever is written to them, so software can keep its own settings there.

Register map (`reg_addr`): 0 is control, with the rate in bits [1:0]. 1 is enable, with the interrupt enable in bit 0. 2 is flag, with the tick flag in bit 0; its other bits read 0. Address 3 reads 0 and ignores writes.

Top module: `rti_gen`

## Requirements
- R1: The period between ticks is `2^(BASE_LOG2+N)` cycles, where N is control bits [1:0] (N = 0..3).
- R2: When a period ends, the tick flag (flag register bit 0) is set on the next clock edge. It stays set until it is cleared.
- R3: A write to address 0 restarts the period count from zero, so the next tick comes one full new period after the write edge. The write itself does not set the flag, even when it lands on the cycle a tick would have fired.
- R4: Writing 1 to flag register bit 0 clears the flag. Writing 0 to it has no effect. If a tick and the clearing write occur on the same edge, the tick wins and the flag stays set.
- R5: Reset clears the control register (selecting the shortest period), the enable register and the flag. The first period then runs from the release of reset.
- R6: `irq` equals the tick flag ANDed with enable bit 0.
- R7: Each period is timed from the previous tick, not from the moment software clears the flag, so a late acknowledge does not shift later ticks.
- R8: Control bits [7:2] and enable bits [7:1] are stored and read back unchanged. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The divider runs at all four rates. The bench tells the period lengths apart because it compares the flag and `irq` against a reference model on every cycle. A control rewrite in the middle of a period, and another on the exact cycle of a tick, show that the timing restarts and that the flag is not set. A clear that arrives late separates a drift-free period from one timed from the acknowledge. Writes of 0 to the flag, a clear on the same edge as a tick, and toggling the enable separate the clear, tick-priority and gating rules.

// File: rtl/rti_pkg.sv
package rti_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_EN   = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;
    localparam int         RATE_LSB  = 0;
    localparam int         EN_BIT    = 0;
    localparam int         FLAG_BIT  = 0;
endpackage

// File: rtl/rti_rate_div.sv
module rti_rate_div #(
    parameter int BASE_LOG2 = 13,
    parameter int RATE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    input  logic              restart,
    output logic              tick
);
    localparam int CNT_W = BASE_LOG2 + (1 << RATE_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [CNT_W:0]   span_full;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        span_full = (CNT_W+1)'(1) << (BASE_LOG2 + int'(rate));
        last_cnt  = CNT_W'(span_full - 1'b1);
        tick      = (st_q.cnt == last_cnt) && !restart;
        st_d      = st_q;
        if (restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a restart brings the count back to zero
    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));
    // R7: after a tick, the next period starts from zero at once
    assert_tick_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == '0));
    // R1: the count never runs past the end of the selected period
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && $stable(rate)) |=> (st_q.cnt <= last_cnt));
endmodule

// File: rtl/rti_regs.sv
module rti_regs #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              tick,
    output logic [7:0]        reg_rdata,
    output logic [RATE_W-1:0] rate,
    output logic              restart,
    output logic              irq
);
    import rti_pkg::*;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] en;
        logic       flag;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic wr_ctrl, wr_en, clr_flag;

    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
        wr_en    = reg_wr && (reg_addr == ADDR_EN);
        clr_flag = reg_wr && (reg_addr == ADDR_FLAG) && reg_wdata[FLAG_BIT];
        st_d     = st_q;
        if (wr_ctrl) st_d.ctrl = reg_wdata;
        if (wr_en)   st_d.en   = reg_wdata;
        if (tick)          st_d.flag = 1'b1;
        else if (clr_flag) st_d.flag = 1'b0;
        restart = wr_ctrl;
        rate    = st_q.ctrl[RATE_LSB +: RATE_W];
        irq     = st_q.flag && st_q.en[EN_BIT];
        case (reg_addr)
            ADDR_CTRL: reg_rdata = st_q.ctrl;
            ADDR_EN:   reg_rdata = st_q.en;
            ADDR_FLAG: reg_rdata = 8'(st_q.flag) << FLAG_BIT;
            default:   reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the flag only rises after a tick
    assert_flag_from_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(tick));
    // R3: a control write never sets the flag
    assert_ctrl_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !st_q.flag) |=> !st_q.flag);
    // R4: a clear with no tick drops the flag
    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !tick) |=> !st_q.flag);
    // R6: the request is never raised while disabled
    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.en[EN_BIT] && st_q.flag));
endmodule

// File: rtl/rti_gen.sv
module rti_gen #(
    parameter int BASE_LOG2 = 13,
    parameter int RATE_W    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    logic [RATE_W-1:0] rate;
    logic              restart;
    logic              tick;

    rti_regs #(.RATE_W(RATE_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .tick(tick), .reg_rdata(reg_rdata),
        .rate(rate), .restart(restart), .irq(irq)
    );

    rti_rate_div #(.BASE_LOG2(BASE_LOG2), .RATE_W(RATE_W)) div_i (
        .clk(clk), .rst_n(rst_n), .rate(rate), .restart(restart), .tick(tick)
    );
endmodule

// File: tb/rti_gen_tb_top.sv
module rti_gen_tb_top;
    localparam int BASE = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cycle = 0;
    int m_cnt = 0;
    int m_ctrl = 0;
    int m_en = 0;
    int m_flag = 0;
    int m_ticks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rti_gen #(.BASE_LOG2(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // behavioural reference: period in cycles, tick when the count completes
    always @(posedge clk) begin
        if (rst_n) begin
            int period;
            bit wc, tk, clr;
            period = 1 << (BASE + (m_ctrl % 4));
            wc  = reg_wr && reg_addr == 2'd0;
            clr = reg_wr && reg_addr == 2'd2 && reg_wdata[0];
            tk  = !wc && (m_cnt == period - 1);
            if (tk) begin m_flag = 1; m_ticks++; end
            else if (clr) m_flag = 0;
            if (wc || tk) m_cnt = 0; else m_cnt++;
            if (wc) m_ctrl = reg_wdata;
            if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata;
        end
        cycle++;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycle);
        end
    endtask

    // R1 R2 R6 R7: cycle-accurate comparison of the request line
    always @(negedge clk) begin
        if (rst_n && !done) check("R6/R2", int'(irq), (m_flag != 0 && (m_en & 1) != 0) ? 1 : 0);
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input int exp);
        @(negedge clk);
        reg_addr = a;
        #1 check(req, int'(reg_rdata), exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int t0;
        #1;
        rd("R5 ctrl", 2'd0, 0);
        rd("R5 en", 2'd1, 0);
        rd("R5 flag", 2'd2, 0);
        @(negedge clk); rst_n = 1'b1;
        rd("R5 ctrl after release", 2'd0, 0);
        wr(2'd1, 8'h01);
        // R1 rate 0 and R5 first period from reset
        idle((1 << BASE) - 5);
        rd("R5 flag before first tick", 2'd2, 0);
        idle(4);
        rd("R1 flag after first tick", 2'd2, 1);
        // R4 writing 0 has no effect, writing 1 clears
        wr(2'd2, 8'hFE);
        rd("R4 zero write", 2'd2, 1);
        wr(2'd2, 8'h01);
        rd("R4 clear", 2'd2, 0);
        // R1 other rates
        for (int r = 1; r < 4; r++) begin
            wr(2'd0, 8'(r));
            t0 = m_ticks;
            idle((1 << (BASE + r)) * 2 + 4);
            check("R1 tick count", m_ticks - t0, 2);
            rd("R1 flag", 2'd2, 1);
            wr(2'd2, 8'h01);
        end
        // R8 upper bits stored, rate taken from low bits
        wr(2'd0, 8'hA4);
        rd("R8 ctrl readback", 2'd0, 8'hA4);
        wr(2'd1, 8'h5B);
        rd("R8 en readback", 2'd1, 8'h5B);
        rd("R8 addr3", 2'd3, 0);
        wr(2'd3, 8'hFF);
        rd("R8 addr3 write ignored", 2'd3, 0);
        wr(2'd2, 8'h01);
        // R3 rewrite mid-period postpones the tick
        wr(2'd0, 8'h00);
        idle((1 << BASE) / 2);
        wr(2'd0, 8'h00);
        idle((1 << BASE) - 4);
        rd("R3 no tick after restart", 2'd2, 0);
        idle(4);
        rd("R3 tick one period after rewrite", 2'd2, 1);
        wr(2'd2, 8'h01);
        // R3 rewrite on the tick cycle
        while (m_cnt != (1 << BASE) - 2) @(negedge clk);
        wr(2'd0, 8'h00);
        rd("R3 write at tick sets no flag", 2'd2, 0);
        // R4 clear on the same edge as a tick: tick wins
        while (m_cnt != (1 << BASE) - 2) @(negedge clk);
        wr(2'd2, 8'h01);
        rd("R4 tick beats clear", 2'd2, 1);
        // R7 late clear, ticks stay on schedule
        idle((1 << BASE) + 10);
        wr(2'd2, 8'h01);
        t0 = m_ticks;
        idle((1 << BASE) * 3);
        check("R7 ticks after late clear", m_ticks - t0, 3);
        // R6 disabled: irq low while flag set
        wr(2'd1, 8'h00);
        idle((1 << BASE) + 2);
        rd("R6 flag set", 2'd2, 1);
        check("R6 irq masked", int'(irq), 0);
        wr(2'd1, 8'h01);
        #1 check("R6 irq enabled", int'(irq), 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule